// File: doc/BRIEF.md
# SPI EEPROM Page-Write Slave

This block is the write side of a small serial EEPROM behind an SPI slave port. While chip select is low it samples the serial input on each rising edge of the serial clock, assembles bytes most significant bit first, and decodes the first byte of each frame as a command. Three commands are recognised. A write-enable command arms a latch. A page write carries an address and then any number of data bytes. A status write carries one data byte.

Data bytes of a page write go into a page buffer. The within-page part of the address advances after every byte and wraps inside the page, so a long burst overwrites the bytes it loaded earlier. Raising chip select after a whole number of bytes starts an internal write cycle. That cycle is modelled as a fixed count of system clocks. While it runs, a busy bit is visible and all new commands are refused. When the count expires, the buffered bytes (or the new status bits) are committed, and both the busy bit and the write-enable latch drop.

The serial pins are sampled by the system clock through two-stage synchronisers. The storage array has a combinational peek port, and the status byte is a plain output.

Top module: `spi_ee_pgwr`

## Requirements
- R1: The serial input is taken on rising serial-clock edges while chip select is low, most significant bit first. A frame that ends with a partial byte (1 to 7 extra bits) starts no write cycle and leaves array and status unchanged.
- R2: Opcode 0x06 sets the write-enable latch, which is visible as status bit 1, unless a write cycle is running.
- R3: Opcode 0x02 is followed by ceil(ADDR_W/8) address bytes, of which the low ADDR_W bits are used, and then by data bytes. When chip select rises after at least one whole data byte with the latch set, a write cycle starts, and the bytes are in the array once busy has dropped.
- R4: After each data byte only the low log2(PAGE_BYTES) address bits advance. The page bits stay constant, so a burst never touches another page.
- R5: Past the last byte of a page, the next byte goes to the first byte of the same page. Bytes sent later in the burst replace bytes sent earlier at the same location.
- R6: Status bit 0 (busy) is high for exactly WRITE_CYCLES system clocks per accepted write cycle.
- R7: The write-enable latch is clear once a write cycle has completed.
- R8: A page write or status write issued with the latch clear starts no cycle and changes neither the array nor the status.
- R9: Opcode 0x01 followed by exactly one data byte, with the latch set, starts a write cycle whose completion loads data bits 7:2 into status bits 7:2. Status bits 1:0 are never written. A status write carrying more than one data byte is ignored.
- R10: While busy, every command (write-enable, page write, status write) is ignored, and the pending cycle still commits its own data.
- R11: After reset the status byte is 0x00 and every array byte reads 0xFF.
- R12: Array bytes of the addressed page that a burst did not load keep their previous contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data from the host |
| peek_addr | input | ADDR_W | Array address for the peek port |
| peek_data | output | 8 | Array byte at peek_addr (combinational) |
| status | output | 8 | {stored bits 7:2, write-enable latch, busy} |

## Verification
The bench builds the block with ADDR_W=6, PAGE_BYTES=8 and WRITE_CYCLES=600. This gives a 64-byte array of eight pages that the bench compares in full after every step. Eight-byte pages let short bursts cross the page end and wrap several times. The 600-clock cycle is long enough for whole command frames to arrive while busy is still high, so the refusal of commands during a write cycle can be seen.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  localparam logic [7:0] CMD_ARM      = 8'h06;
  localparam logic [7:0] CMD_PAGE_WR  = 8'h02;
  localparam logic [7:0] CMD_STAT_WR  = 8'h01;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_ADDR,
    ST_DATA,
    ST_STAT,
    ST_SKIP
  } ctrl_st_t;

endpackage

// File: rtl/spi_ee_shift.sv
module spi_ee_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  output logic       byte_vld,
  output logic [7:0] byte_dat,
  output logic       frame_end,
  output logic       frame_end_clean
);

  logic [1:0] sck_m, cs_m, si_m;
  logic       sck_d, cs_d;
  logic [6:0] sh_q, sh_n;
  logic [2:0] bcnt_q, bcnt_n;
  logic       vld_q, vld_n;
  logic [7:0] dat_q, dat_n;
  logic       in_frame, sck_rise, take;

  always_comb begin
    in_frame = ~cs_m[1];
    sck_rise = sck_m[1] & ~sck_d;
    take     = in_frame & sck_rise;
    bcnt_n   = in_frame ? (take ? bcnt_q + 3'd1 : bcnt_q) : 3'd0;
    sh_n     = take ? {sh_q[5:0], si_m[1]} : sh_q;
    vld_n    = take && (bcnt_q == 3'd7);
    dat_n    = vld_n ? {sh_q, si_m[1]} : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m  <= 2'b00;
      cs_m   <= 2'b11;
      si_m   <= 2'b00;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
      sh_q   <= '0;
      bcnt_q <= '0;
      vld_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      sck_m  <= {sck_m[0], sck};
      cs_m   <= {cs_m[0], cs_n};
      si_m   <= {si_m[0], si};
      sck_d  <= sck_m[1];
      cs_d   <= cs_m[1];
      sh_q   <= sh_n;
      bcnt_q <= bcnt_n;
      vld_q  <= vld_n;
      dat_q  <= dat_n;
    end
  end

  assign byte_vld        = vld_q;
  assign byte_dat        = dat_q;
  assign frame_end       = cs_m[1] & ~cs_d;
  assign frame_end_clean = frame_end & (bcnt_q == 3'd0);

  // R1: a deselect drops any partial byte
  a_r1_abort_partial: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (bcnt_q == 3'd0));

  // R1: bytes are only produced from bits taken inside a frame
  a_r1_byte_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(in_frame));

endmodule

// File: rtl/spi_ee_pagebuf.sv
module spi_ee_pagebuf #(
  parameter int PAGE_BYTES = 16,
  parameter int IDX_W      = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [IDX_W-1:0]        start_idx,
  input  logic                    wr_en,
  input  logic [7:0]              wr_dat,
  output logic [PAGE_BYTES*8-1:0] page_dat,
  output logic [PAGE_BYTES-1:0]   page_mask
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);

  logic [IDX_W-1:0] ptr_q, ptr_n;

  always_comb begin
    if (start)
      ptr_n = start_idx;
    else if (wr_en)
      ptr_n = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
    else
      ptr_n = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic       hit;
    logic [7:0] dat_q;
    logic       mask_q, mask_n;

    assign hit = wr_en && (ptr_q == IDX_W'(g));

    always_comb begin
      if (start)    mask_n = 1'b0;
      else if (hit) mask_n = 1'b1;
      else          mask_n = mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q  <= '0;
        mask_q <= 1'b0;
      end else begin
        mask_q <= mask_n;
        if (hit) dat_q <= wr_dat;
      end
    end

    assign page_dat[g*8 +: 8] = dat_q;
    assign page_mask[g]       = mask_q;
  end

  // R5: the pointer wraps from the last slot to the first
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !start && ptr_q == LAST_IDX) |=> (ptr_q == '0));

  // R4: otherwise the pointer advances by one
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !start && ptr_q != LAST_IDX) |=> (ptr_q == $past(ptr_q) + 1'b1));

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int IDX_W      = $clog2(PAGE_BYTES),
  parameter int PG_W       = ADDR_W - IDX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pg_we,
  input  logic [PG_W-1:0]         pg_sel,
  input  logic [PAGE_BYTES*8-1:0] pg_dat,
  input  logic [PAGE_BYTES-1:0]   pg_mask,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_dat
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH*8-1:0] cells;

  for (genvar a = 0; a < DEPTH; a++) begin : g_cell
    localparam int PG = a / PAGE_BYTES;
    localparam int BY = a % PAGE_BYTES;
    logic       hit;
    logic [7:0] cell_q;

    assign hit = pg_we && (pg_sel == PG_W'(PG)) && pg_mask[BY];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cell_q <= 8'hFF;
      else if (hit) cell_q <= pg_dat[BY*8 +: 8];
    end

    assign cells[a*8 +: 8] = cell_q;
  end

  assign rd_dat = cells[{rd_addr, 3'b000} +: 8];

endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 5000,
  parameter int IDX_W        = $clog2(PAGE_BYTES),
  parameter int PG_W         = ADDR_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic [7:0]       byte_dat,
  input  logic             frame_end,
  input  logic             frame_end_clean,
  input  logic             buf_any,
  output logic             pb_start,
  output logic [IDX_W-1:0] pb_idx,
  output logic             pb_wr,
  output logic             pg_we,
  output logic [PG_W-1:0]  pg_sel,
  output logic [7:0]       status
);

  localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
  localparam int AF_W       = ADDR_BYTES * 8;
  localparam int AC_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int CNT_W      = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;

  ctrl_st_t         st_q, st_n;
  logic [AC_W-1:0]  acnt_q, acnt_n;
  logic [AF_W-1:0]  addr_q, addr_n;
  logic [PG_W-1:0]  page_q, page_n;
  logic             wel_q, wel_n;
  logic             busy_q, busy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             kind_q, kind_n;     // 1: status commit, 0: page commit
  logic [5:0]       srbuf_q, srbuf_n;
  logic             srgot_q, srgot_n;
  logic [5:0]       sr_q, sr_n;

  always_comb begin
    st_n     = st_q;
    acnt_n   = acnt_q;
    addr_n   = addr_q;
    page_n   = page_q;
    wel_n    = wel_q;
    busy_n   = busy_q;
    cnt_n    = cnt_q;
    kind_n   = kind_q;
    srbuf_n  = srbuf_q;
    srgot_n  = srgot_q;
    sr_n     = sr_q;
    pb_start = 1'b0;
    pg_we    = 1'b0;

    // write cycle countdown and commit
    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_n = 1'b0;
        wel_n  = 1'b0;
        if (kind_q) sr_n  = srbuf_q;
        else        pg_we = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end

    // byte decode
    if (byte_vld) begin
      case (st_q)
        ST_OPCODE: begin
          st_n = ST_SKIP;
          if (!busy_q) begin
            if (byte_dat == CMD_ARM) begin
              wel_n = 1'b1;
            end else if (byte_dat == CMD_PAGE_WR && wel_q) begin
              st_n   = ST_ADDR;
              acnt_n = '0;
            end else if (byte_dat == CMD_STAT_WR && wel_q) begin
              st_n    = ST_STAT;
              srgot_n = 1'b0;
            end
          end
        end
        ST_ADDR: begin
          addr_n = AF_W'({addr_q, byte_dat});
          if (acnt_q == AC_W'(ADDR_BYTES - 1)) begin
            st_n     = ST_DATA;
            pb_start = 1'b1;
            page_n   = addr_n[ADDR_W-1:IDX_W];
          end else begin
            acnt_n = acnt_q + 1'b1;
          end
        end
        ST_STAT: begin
          if (!srgot_q) begin
            srbuf_n = byte_dat[7:2];
            srgot_n = 1'b1;
          end else begin
            st_n    = ST_SKIP;
            srgot_n = 1'b0;
          end
        end
        default: ;
      endcase
    end

    // end of frame: start the write cycle when the frame was complete
    if (frame_end) begin
      st_n    = ST_OPCODE;
      acnt_n  = '0;
      srgot_n = 1'b0;
      if (frame_end_clean && !busy_q) begin
        if (st_q == ST_DATA && buf_any) begin
          busy_n = 1'b1;
          kind_n = 1'b0;
          cnt_n  = CNT_W'(WRITE_CYCLES - 1);
        end else if (st_q == ST_STAT && srgot_q) begin
          busy_n = 1'b1;
          kind_n = 1'b1;
          cnt_n  = CNT_W'(WRITE_CYCLES - 1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_OPCODE;
      acnt_q  <= '0;
      addr_q  <= '0;
      page_q  <= '0;
      wel_q   <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      kind_q  <= 1'b0;
      srbuf_q <= '0;
      srgot_q <= 1'b0;
      sr_q    <= '0;
    end else begin
      st_q    <= st_n;
      acnt_q  <= acnt_n;
      addr_q  <= addr_n;
      page_q  <= page_n;
      wel_q   <= wel_n;
      busy_q  <= busy_n;
      cnt_q   <= cnt_n;
      kind_q  <= kind_n;
      srbuf_q <= srbuf_n;
      srgot_q <= srgot_n;
      sr_q    <= sr_n;
    end
  end

  assign pb_idx = addr_n[IDX_W-1:0];
  assign pb_wr  = byte_vld && (st_q == ST_DATA);
  assign pg_sel = page_q;
  assign status = {sr_q, wel_q, busy_q};

  // R6: busy stays up until the countdown has run out
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q);

  // R7: the latch is clear whenever a cycle has just finished
  a_r7_wel_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !wel_q);

  // R8: a cycle only starts with the latch armed
  a_r8_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wel_q));

  // R10: status bits hold while a cycle is still counting
  a_r10_sr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> $stable(sr_q));

  // R10: no new page load while busy
  a_r10_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !pb_start);

endmodule

// File: rtl/spi_ee_pgwr.sv
module spi_ee_pgwr #(
  parameter int ADDR_W       = 8,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [7:0]        peek_data,
  output logic [7:0]        status
);

  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - IDX_W;

  logic [1:0] rst_ff;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_i_n = rst_ff[1];

  logic                    byte_vld, frame_end, frame_end_clean;
  logic [7:0]              byte_dat;
  logic                    pb_start, pb_wr, pg_we;
  logic [IDX_W-1:0]        pb_idx;
  logic [PG_W-1:0]         pg_sel;
  logic [PAGE_BYTES*8-1:0] page_dat;
  logic [PAGE_BYTES-1:0]   page_mask;

  spi_ee_shift i_shift (
    .clk             (clk),
    .rst_n           (rst_i_n),
    .sck             (spi_sck),
    .cs_n            (spi_cs_n),
    .si              (spi_si),
    .byte_vld        (byte_vld),
    .byte_dat        (byte_dat),
    .frame_end       (frame_end),
    .frame_end_clean (frame_end_clean)
  );

  spi_ee_ctrl #(
    .ADDR_W       (ADDR_W),
    .PAGE_BYTES   (PAGE_BYTES),
    .WRITE_CYCLES (WRITE_CYCLES),
    .IDX_W        (IDX_W),
    .PG_W         (PG_W)
  ) i_ctrl (
    .clk             (clk),
    .rst_n           (rst_i_n),
    .byte_vld        (byte_vld),
    .byte_dat        (byte_dat),
    .frame_end       (frame_end),
    .frame_end_clean (frame_end_clean),
    .buf_any         (|page_mask),
    .pb_start        (pb_start),
    .pb_idx          (pb_idx),
    .pb_wr           (pb_wr),
    .pg_we           (pg_we),
    .pg_sel          (pg_sel),
    .status          (status)
  );

  spi_ee_pagebuf #(
    .PAGE_BYTES (PAGE_BYTES),
    .IDX_W      (IDX_W)
  ) i_pagebuf (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start     (pb_start),
    .start_idx (pb_idx),
    .wr_en     (pb_wr),
    .wr_dat    (byte_dat),
    .page_dat  (page_dat),
    .page_mask (page_mask)
  );

  spi_ee_array #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .IDX_W      (IDX_W),
    .PG_W       (PG_W)
  ) i_array (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .pg_we   (pg_we),
    .pg_sel  (pg_sel),
    .pg_dat  (page_dat),
    .pg_mask (page_mask),
    .rd_addr (peek_addr),
    .rd_dat  (peek_data)
  );

endmodule

// File: tb/test_spi_ee_pgwr.sv
module test_spi_ee_pgwr;

  localparam int CLK_PERIOD = 10;
  localparam int TB_ADDR_W  = 6;
  localparam int TB_PAGE    = 8;
  localparam int TB_WC      = 600;
  localparam int TB_DEPTH   = 1 << TB_ADDR_W;

  // {address, byte count, data seed}
  // entries 4..6 cross the page end (R4, R5)
  localparam logic [23:0] VEC [6] = '{
    24'h00_01_A5, 24'h08_08_3C, 24'h13_03_71,
    24'h1E_04_5A, 24'h22_0B_C3, 24'h3F_02_0F
  };

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 sck = 1'b0;
  logic                 cs_n = 1'b1;
  logic                 si = 1'b0;
  logic [TB_ADDR_W-1:0] peek_addr = '0;
  logic [7:0]           peek_data;
  logic [7:0]           status;

  logic [7:0] model [TB_DEPTH];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int blen;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_ee_pgwr #(
    .ADDR_W       (TB_ADDR_W),
    .PAGE_BYTES   (TB_PAGE),
    .WRITE_CYCLES (TB_WC)
  ) i_spi_ee_pgwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_sck   (sck),
    .spi_cs_n  (cs_n),
    .spi_si    (si),
    .peek_addr (peek_addr),
    .peek_data (peek_data),
    .status    (status)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i >= 8 - n; i--) begin
      si = b[i];
      tick(4);
      sck = 1'b1;
      tick(4);
      sck = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
  endtask

  task automatic sel_on;
    cs_n = 1'b0;
    tick(4);
  endtask

  task automatic sel_off;
    tick(4);
    cs_n = 1'b1;
  endtask

  task automatic arm;
    sel_on();
    send_byte(8'h06);
    sel_off();
    tick(8);
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int k);
    return seed ^ 8'(k * 37);
  endfunction

  task automatic page_write(input logic [7:0] addr, input int n,
                            input logic [7:0] seed, input bit apply);
    int base;
    int idx;
    base = int'(addr[TB_ADDR_W-1:0]) & ~(TB_PAGE - 1);
    idx  = int'(addr) % TB_PAGE;
    sel_on();
    send_byte(8'h02);
    send_byte(addr);
    for (int k = 0; k < n; k++) begin
      send_byte(pat(seed, k));
      if (apply) model[base + idx] = pat(seed, k);
      idx = (idx + 1) % TB_PAGE;
    end
    sel_off();
  endtask

  task automatic stat_write(input logic [7:0] v, input int nbytes);
    sel_on();
    send_byte(8'h01);
    for (int k = 0; k < nbytes; k++) send_byte(v);
    sel_off();
  endtask

  task automatic measure_busy(output int len);
    int w;
    w   = 0;
    len = 0;
    while (!status[0] && w < 40) begin
      tick(1);
      w++;
    end
    while (status[0] && len < 4 * TB_WC) begin
      tick(1);
      len++;
    end
  endtask

  task automatic check_mem(input string req);
    int bad;
    logic [7:0] act;
    bad = -1;
    act = '0;
    for (int a = 0; a < TB_DEPTH; a++) begin
      peek_addr = TB_ADDR_W'(a);
      #1;
      if (bad < 0 && peek_data !== model[a]) begin
        bad = a;
        act = peek_data;
      end
    end
    tick(1);
    check(bad < 0, req, $sformatf("array byte %0h", bad), act,
          (bad < 0) ? 0 : model[bad]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < TB_DEPTH; a++) model[a] = 8'hFF;
    tick(5);
    rst_n = 1'b1;
    tick(6);

    // R11: reset state
    check(status == 8'h00, "R11", "status after reset", status, 8'h00);
    check_mem("R11");

    // table walk: R2, R3, R4, R5, R6, R7, R12
    for (int v = 0; v < 6; v++) begin
      arm();
      check(status[1] == 1'b1, "R2", "latch after arm", status, 8'h02);
      page_write(VEC[v][23:16], int'(VEC[v][15:8]), VEC[v][7:0], 1'b1);
      measure_busy(blen);
      check(blen == TB_WC, "R6", "busy length", blen, TB_WC);
      tick(2);
      check(status[1] == 1'b0, "R7", "latch after cycle", status, 8'h00);
      check_mem("R3 R4 R5 R12");
    end

    // R8: page write without the latch
    page_write(8'h05, 2, 8'hEE, 1'b0);
    measure_busy(blen);
    check(blen == 0, "R8", "busy on unarmed write", blen, 0);
    check_mem("R8");

    // R8: status write without the latch
    stat_write(8'hFC, 1);
    measure_busy(blen);
    tick(2);
    check(blen == 0, "R8", "busy on unarmed status write", blen, 0);
    check(status == 8'h00, "R8", "status after unarmed write", status, 8'h00);

    // R9: armed status write, bits 1:0 not writable
    arm();
    stat_write(8'hFF, 1);
    measure_busy(blen);
    tick(2);
    check(blen == TB_WC, "R9", "busy length on status write", blen, TB_WC);
    check(status == 8'hFC, "R9", "status after load", status, 8'hFC);

    // R9: two data bytes make the status write void
    arm();
    stat_write(8'h00, 2);
    measure_busy(blen);
    tick(2);
    check(blen == 0, "R9", "busy on long status write", blen, 0);
    check(status == 8'hFE, "R9", "status after long write", status, 8'hFE);

    // R1: trailing partial byte aborts the write
    sel_on();
    send_byte(8'h02);
    send_byte(8'h28);
    send_byte(8'h11);
    send_bits(8'hA0, 4);
    sel_off();
    measure_busy(blen);
    tick(2);
    check(blen == 0, "R1", "busy after partial byte", blen, 0);
    check(status == 8'hFE, "R1", "status after partial byte", status, 8'hFE);
    check_mem("R1");

    // R10: commands arriving during a cycle are refused
    page_write(8'h30, 2, 8'h99, 1'b1);
    tick(10);
    sel_on();
    send_byte(8'h06);
    sel_off();
    tick(8);
    page_write(8'h01, 2, 8'h55, 1'b0);
    tick(4);
    check(status[0] == 1'b1, "R10", "still busy after frames", status, 8'h01);
    while (status[0]) tick(1);
    tick(2);
    check(status == 8'hFC, "R10", "status after busy frames", status, 8'hFC);
    check_mem("R10");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule